// File: doc/BRIEF.md
# SPI Nonvolatile Memory Slave

This block is the device end of a serial memory reached over SPI in mode 0 (clock idles low, the slave samples SI on the rising SCK edge and changes SO on the falling edge). It holds a byte-wide array inside the block. A host frames each command with chip select low. The first byte is the command code. Read and write commands then carry a 16-bit address, most significant byte first, followed by a stream of data bytes. No page buffer exists: each write byte goes into the array as soon as its eighth bit arrives, and the internal address counter steps to the next byte and wraps at the top of the array.

A one-byte status word holds a write-enable latch, a two-bit protection field that locks an upper fraction of the array, and one spare writable flag. A write burst that runs into the locked zone stops advancing its address and drops every byte that follows. A fast-read command adds one dummy byte of latency before data. The block runs from a single system clock. SCK, chip select and SI reach it as signals already synchronous to that clock, with each SCK half period lasting several system clocks. The array holds 2^ADDR_W bytes, and ADDR_W may range from 9 to 16, with 14 giving the full 16K x 8 size. The default of 10 keeps elaboration small, and the requirements below use that default.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset so_oe is 0, and a status read returns 00h.
- R2: Command 06h in its own frame sets the write-enable latch, which reads back as status bit 1. Command 05h returns the status byte {bit7 flag, 000, protect[1:0], latch, 0} on every byte for as long as chip select stays low.
- R3: Command 02h, when accepted, takes two address bytes MSB first, and only the low ADDR_W bits are used. Each complete data byte, MSB first, is stored at the current address. The address then advances by one, and after the last address (3FFh by default) it wraps to 0.
- R4: Command 02h or 01h arriving with the latch clear is ignored, so the array and the status stay unchanged. When chip select rises after an accepted 02h or 01h frame, the latch clears.
- R5: A data byte that is only partly shifted in when chip select rises is not stored.
- R6: Command 03h returns data MSB first from the addressed byte, with the first bit driven after the falling edge that ends the last address bit. It continues through sequential addresses with wraparound, and SI is ignored while data is returned.
- R7: Command 0Bh behaves like 03h except that one dummy byte follows the address. SO stays undriven (so_oe 0) during that dummy byte.
- R8: Command 01h, when accepted, writes only status bits 7, 3 and 2 from its data byte. Bits 6:4 and 0 always read as 0.
- R9: Protect field 00 locks nothing, 01 locks addresses whose two top bits are 11, 10 locks those whose top bit is 1, and 11 locks the whole array. A write burst that reaches a locked address stores nothing there, holds its address, and drops all remaining bytes.
- R10: An unknown command code leaves so_oe at 0 for the rest of the frame and changes neither the array nor the status.
- R11: Whenever chip select has been high for more than one clock, so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, mode 0, synchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for so; 0 means high impedance |

## Verification
The bench aims at the places where a counter or a flag can slip by one. It tests wraparound from the top address to zero on both write and read. A design that got this wrong would read from a stale or out-of-range location. It issues a write with the upper address bits set, which a design would misroute if it used those bits. It also cuts a byte short at chip-select release, and a faulty design would store that fragment. The protection tests start bursts just below the quarter and half boundaries. A design that kept counting, or stored past the boundary, would leave the following bytes altered. The bench also checks that the enable latch clears only after an accepted write, that a fast read holds SO undriven through its dummy byte, and that an unknown code never turns on the output driver.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_FAST  = 8'h0B;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_WRSR  = 8'h01;

    typedef enum logic [3:0] {
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_DUMMY,
        ST_RDATA,
        ST_WDATA,
        ST_SRD,
        ST_SWR,
        ST_SDONE,
        ST_SKIP
    } frame_st_t;

    typedef enum logic [1:0] {
        K_READ,
        K_FAST,
        K_WRITE
    } acc_kind_t;

    typedef struct packed {
        logic       flag7;
        logic [1:0] prot;
        logic       wel;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {s.flag7, 3'b000, s.prot, s.wel, 1'b0};
    endfunction

    function automatic logic zone_locked(logic [1:0] prot, logic [1:0] top);
        case (prot)
            2'b00:   return 1'b0;
            2'b01:   return (top == 2'b11);
            2'b10:   return top[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_data,
    output logic              sck_fall,
    output logic              at_boundary,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              so_bit
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sck_d;
    logic              sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign sck_rise    = sck & ~sck_d & ~cs_n;
    assign sck_fall    = ~sck & sck_d & ~cs_n;
    assign at_boundary = (bit_cnt == '0);
    assign so_bit      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d      <= 1'b0;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
        end else begin
            sck_d      <= sck;
            byte_valid <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], si};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt    <= '0;
                    byte_valid <= 1'b1;
                    rx_byte    <= {rx_sh[BYTE_W-2:0], si};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (sck_fall) begin
                tx_sh <= load_en ? load_data : {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // R5: a completed byte is reported once, never on back-to-back clocks
    a_r5_single_byte_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R5: no byte is reported in the clock after chip select was high
    a_r5_no_byte_when_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !byte_valid);

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck_fall,
    input  logic              at_boundary,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rd_data,
    output logic              load_en,
    output logic [7:0]        load_data,
    output logic              so_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int HI_W = ADDR_W - 8;

    frame_st_t         st_q;
    acc_kind_t         kind_q;
    stat_t             stat_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_frame_q;
    logic              oe_q;
    logic              locked;

    assign locked    = zone_locked(stat_q.prot, addr_q[ADDR_W-1 -: 2]);
    assign load_en   = sck_fall & at_boundary & ((st_q == ST_RDATA) | (st_q == ST_SRD));
    assign load_data = (st_q == ST_SRD) ? stat_byte(stat_q) : rd_data;
    assign mem_we    = byte_valid & (st_q == ST_WDATA) & ~locked;
    assign mem_addr  = addr_q;
    assign mem_wdata = rx_byte;
    assign so_oe     = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_OPC;
            kind_q     <= K_READ;
            stat_q     <= '0;
            hi_q       <= '0;
            addr_q     <= '0;
            wr_frame_q <= 1'b0;
            oe_q       <= 1'b0;
        end else if (cs_n) begin
            st_q <= ST_OPC;
            oe_q <= 1'b0;
            if (wr_frame_q) begin
                stat_q.wel <= 1'b0;
                wr_frame_q <= 1'b0;
            end
        end else begin
            if (load_en) begin
                oe_q <= 1'b1;
                if (st_q == ST_RDATA) begin
                    addr_q <= addr_q + 1'b1;
                end
            end
            if (byte_valid) begin
                case (st_q)
                    ST_OPC: begin
                        case (rx_byte)
                            CMD_WREN: begin
                                stat_q.wel <= 1'b1;
                                st_q       <= ST_SKIP;
                            end
                            CMD_READ: begin
                                kind_q <= K_READ;
                                st_q   <= ST_AHI;
                            end
                            CMD_FAST: begin
                                kind_q <= K_FAST;
                                st_q   <= ST_AHI;
                            end
                            CMD_WRITE: begin
                                if (stat_q.wel) begin
                                    kind_q     <= K_WRITE;
                                    wr_frame_q <= 1'b1;
                                    st_q       <= ST_AHI;
                                end else begin
                                    st_q <= ST_SKIP;
                                end
                            end
                            CMD_RDSR: st_q <= ST_SRD;
                            CMD_WRSR: begin
                                if (stat_q.wel) begin
                                    wr_frame_q <= 1'b1;
                                    st_q       <= ST_SWR;
                                end else begin
                                    st_q <= ST_SKIP;
                                end
                            end
                            default: st_q <= ST_SKIP;
                        endcase
                    end
                    ST_AHI: begin
                        hi_q <= rx_byte[HI_W-1:0];
                        st_q <= ST_ALO;
                    end
                    ST_ALO: begin
                        addr_q <= {hi_q, rx_byte};
                        case (kind_q)
                            K_FAST:  st_q <= ST_DUMMY;
                            K_WRITE: st_q <= ST_WDATA;
                            default: st_q <= ST_RDATA;
                        endcase
                    end
                    ST_DUMMY: st_q <= ST_RDATA;
                    ST_WDATA: begin
                        if (!locked) begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    ST_SWR: begin
                        stat_q.flag7 <= rx_byte[7];
                        stat_q.prot  <= rx_byte[3:2];
                        st_q         <= ST_SDONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: driver is off one clock after chip select is seen high
    a_r11_oe_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !so_oe);

    // R2: the latch only rises after a received enable command byte
    a_r2_wel_set_by_command: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.wel) |-> ($past(byte_valid) && ($past(rx_byte) == CMD_WREN)));

    // R4: no array write happens without the enable latch
    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> stat_q.wel);

    // R10: a skipped frame never drives the output
    a_r10_skip_keeps_tristate: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SKIP) |-> !so_oe);

endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic so_oe
);
    logic              sck_fall;
    logic              at_boundary;
    logic              byte_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              load_en;
    logic [BYTE_W-1:0] load_data;
    logic [BYTE_W-1:0] rd_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;

    spi_bit_engine #(.BYTE_W(BYTE_W)) u_bits (
        .clk         (clk),
        .rst         (rst),
        .sck         (sck),
        .cs_n        (cs_n),
        .si          (si),
        .load_en     (load_en),
        .load_data   (load_data),
        .sck_fall    (sck_fall),
        .at_boundary (at_boundary),
        .byte_valid  (byte_valid),
        .rx_byte     (rx_byte),
        .so_bit      (so)
    );

    spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sck_fall    (sck_fall),
        .at_boundary (at_boundary),
        .byte_valid  (byte_valid),
        .rx_byte     (rx_byte),
        .rd_data     (rd_data),
        .load_en     (load_en),
        .load_data   (load_data),
        .so_oe       (so_oe),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rd_data)
    );

endmodule

// File: tb/spi_fram_slave_tb_top.sv
module spi_fram_slave_tb_top;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int H     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so;
    logic so_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] mdl_mem [DEPTH];
    bit         mdl_wel = 1'b0;
    bit         mdl_f7 = 1'b0;
    logic [1:0] mdl_prot = 2'b00;
    logic       cs_prev = 1'b1;

    always #2 clk = ~clk;

    spi_fram_slave #(.ADDR_W(AW)) dut_i (
        .clk   (clk),
        .rst   (rst),
        .sck   (sck),
        .cs_n  (cs_n),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit mdl_locked(logic [AW-1:0] a);
        case (mdl_prot)
            2'b00:   return 1'b0;
            2'b01:   return a[AW-1:AW-2] == 2'b11;
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] mdl_stat();
        return {mdl_f7, 3'b000, mdl_prot, mdl_wel, 1'b0};
    endfunction

    // per-clock comparison of the output driver against chip select (R11)
    always @(posedge clk) begin
        #1;
        if (!rst && cs_prev && cs_n) begin
            chk(so_oe == 1'b0, "R11", "so_oe while deselected", {7'd0, so_oe}, 8'h00);
        end
        cs_prev = cs_n;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        rx = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_clk(H);
            rx[i] = so;
            if (so_oe) oe_any = 1'b1;
            else       oe_all = 1'b0;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] rx;
        bit a, b;
        xfer(tx, rx, a, b);
    endtask

    task automatic cs_begin();
        wait_clk(H);
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic do_wren();
        cs_begin();
        send(8'h06);
        cs_end();
        mdl_wel = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] addr, input int n, input logic [7:0] seed);
        bit acc;
        logic [AW-1:0] a;
        logic [7:0] b;
        acc = mdl_wel;
        a = addr[AW-1:0];
        cs_begin();
        send(8'h02);
        send(addr[15:8]);
        send(addr[7:0]);
        for (int i = 0; i < n; i++) begin
            b = seed + 8'(i * 37);
            send(b);
            if (acc && !mdl_locked(a)) begin
                mdl_mem[a] = b;
                a = a + 1'b1;
            end
        end
        cs_end();
        if (acc) mdl_wel = 1'b0;
    endtask

    task automatic do_read(input bit fast, input logic [15:0] addr, input int n, input string req);
        logic [7:0] rx;
        bit all, any;
        logic [AW-1:0] a;
        a = addr[AW-1:0];
        cs_begin();
        send(fast ? 8'h0B : 8'h03);
        send(addr[15:8]);
        send(addr[7:0]);
        if (fast) begin
            xfer(8'hFF, rx, all, any);
            chk(!any, "R7", "so_oe during dummy byte", {7'd0, any}, 8'h00);
        end
        for (int i = 0; i < n; i++) begin
            xfer(8'hA5 ^ 8'(i), rx, all, any);
            chk(rx === mdl_mem[a], req, $sformatf("read data at %h", a), rx, mdl_mem[a]);
            chk(all, req, "so_oe during read data", {7'd0, all}, 8'h01);
            a = a + 1'b1;
        end
        cs_end();
    endtask

    task automatic do_rdsr(input int n, input string req);
        logic [7:0] rx;
        bit all, any;
        cs_begin();
        send(8'h05);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, rx, all, any);
            chk(rx === mdl_stat() && all, req, "status byte", rx, mdl_stat());
        end
        cs_end();
    endtask

    task automatic do_wrsr(input logic [7:0] v);
        cs_begin();
        send(8'h01);
        send(v);
        cs_end();
        if (mdl_wel) begin
            mdl_f7   = v[7];
            mdl_prot = v[3:2];
            mdl_wel  = 1'b0;
        end
    endtask

    initial begin
        rst = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R1: reset state
        chk(so_oe == 1'b0, "R1", "so_oe after reset", {7'd0, so_oe}, 8'h00);
        do_rdsr(1, "R1");

        // R2: enable latch visible, status repeats
        do_wren();
        do_rdsr(3, "R2");

        // R3, R6: basic burst write and read back
        do_write(16'h0000, 8, 8'h11);
        do_rdsr(1, "R4");
        do_read(1'b0, 16'h0000, 8, "R6");

        // R4: write without enable is ignored
        do_write(16'h0002, 2, 8'hE0);
        do_read(1'b0, 16'h0002, 2, "R4");

        // fill regions around the protection boundaries
        do_wren();
        do_write(16'h01FC, 8, 8'h40);
        do_wren();
        do_write(16'h02FC, 8, 8'h70);

        // R3: wraparound and ignored upper address bits
        do_wren();
        do_write(16'hC3FE, 4, 8'hB3);
        do_read(1'b0, 16'h03FE, 4, "R3");

        // R7: fast read with dummy byte, also across the wrap
        do_read(1'b1, 16'h7FFE, 4, "R7");

        // R5: partial byte is dropped
        do_wren();
        cs_begin();
        send(8'h02);
        send(8'h00);
        send(8'h04);
        send(8'h5A);
        for (int i = 7; i >= 5; i--) begin
            si = 1'b1;
            wait_clk(H);
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
        cs_end();
        mdl_mem[4] = 8'h5A;
        mdl_wel = 1'b0;
        do_read(1'b0, 16'h0004, 2, "R5");

        // R4: status write without enable is ignored
        do_wrsr(8'h73);
        do_rdsr(1, "R4");

        // R8, R9: whole array locked
        do_wren();
        do_wrsr(8'h7F);
        do_rdsr(1, "R8");
        do_wren();
        do_write(16'h0000, 1, 8'h99);
        do_read(1'b0, 16'h0000, 1, "R9");

        // R8, R9: top quarter locked, burst freezes at boundary
        do_wren();
        do_wrsr(8'h84);
        do_rdsr(1, "R8");
        do_wren();
        do_write(16'h02FE, 4, 8'hC1);
        do_read(1'b0, 16'h02FC, 8, "R9");

        // R9: top half locked
        do_wren();
        do_wrsr(8'h08);
        do_wren();
        do_write(16'h01FE, 3, 8'hD7);
        do_read(1'b0, 16'h01FC, 8, "R9");

        do_wren();
        do_wrsr(8'h00);
        do_rdsr(1, "R8");

        // R10: unknown command code
        do_wren();
        begin
            logic [7:0] rx;
            bit all, any;
            cs_begin();
            send(8'hA5);
            for (int i = 0; i < 3; i++) begin
                xfer(8'h00, rx, all, any);
                chk(!any, "R10", "so_oe after unknown code", {7'd0, any}, 8'h00);
            end
            cs_end();
        end
        do_rdsr(1, "R10");
        do_read(1'b0, 16'h0000, 2, "R10");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule